// File: doc/BRIEF.md
# Flash wait-state access controller

This block sits between a CPU read port and a slow on-chip flash array. It holds a 32-bit configuration word that selects how many clocks each array read takes and whether the bank has power. It runs every array read over that many cycles and keeps recently fetched words in four holding latches. A request that matches a latch is served at once.

Any write to the configuration word empties every latch, so later reads fetch fresh data from the array. A write that arrives while an array read is in progress is held back until that read has completed. While the bank is powered down, requests are answered at once with an error flag and no array read is started. The CPU port uses a valid/ready handshake. The requester holds its request until ready is seen.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the configuration reads 0x8000_9000: the bank is powered and the access code is 9. Ready is low while no request is valid.
- R2: The access code is written from and read back at bits 15:12, and power is written from and read back at bit 31. Writes to bits 30:16 and 11:0 are ignored, and those bits read as zero.
- R3: A request that matches no latch keeps ready low for code+2 cycles: one lookup cycle, then code+1 array cycles. Ready then goes high for one cycle with the array word for that address.
- R4: An access code above 9 gives the same timing as code 9: ready stays low for 11 cycles on a miss.
- R5: A request whose address is held in a valid latch gets ready in the same cycle with the stored word. No array read is started.
- R6: There are four latches, filled in round-robin order starting from latch 0. The fifth distinct miss after a flush replaces the word of the first miss.
- R7: Every configuration write empties all latches and resets the fill order. A re-read of a previously latched address is then a miss.
- R8: When bit 31 is 0, a request gets ready and rsp_err_o high in its first cycle, and arr_en_o stays low. When the bank is powered, rsp_err_o is low on every response.
- R9: A configuration write during an array read leaves the configuration unchanged until that read completes. The read runs with the old timing, and afterwards the write takes effect and flushes the latches.
- R10: A configuration write in an idle cycle holds ready low for any request presented in that same cycle.
- R11: During a miss, arr_en_o is high for exactly code+1 cycles (at most 10), with arr_addr_o equal to the request address throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | AW | Read word address |
| req_ready_o | output | 1 | Request accepted; response fields valid |
| rsp_data_o | output | DW | Read data |
| rsp_err_o | output | 1 | Request refused, bank powered down |
| arr_en_o | output | 1 | Array read in progress |
| arr_addr_o | output | AW | Array word address |
| arr_data_i | input | DW | Array read data, sampled in the last access cycle |

## Verification
The assertions assume that a requester holds req_valid_i and req_addr_i steady until it sees ready. They also assume that arr_data_i is valid by the last cycle of arr_en_o. The bench raises or changes a request only at a falling edge after the previous handshake has finished. It drives the array word as a pure function of arr_addr_o, so the data is always present in time. Configuration writes during an access are issued only in the directed deferral case. Random writes are placed between completed reads, and a power-down request is always answered before the next write restores power.

// File: rtl/flash_wait_pkg.sv
package flash_wait_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned TIM_LSB = 12;
  localparam int unsigned TIM_MSB = 15;
  localparam int unsigned PWR_BIT = 31;
  localparam logic [3:0]  TIM_SAFE = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} seq_st_e;

  typedef struct packed {
    logic       pwr;
    logic [3:0] tim;
  } cfg_t;
endpackage

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
  import flash_wait_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.pwr <= 1'b1;
      cfg_q.tim <= TIM_SAFE;
    end else if (we_i) begin
      cfg_q.pwr <= wdata_i[PWR_BIT];
      cfg_q.tim <= wdata_i[TIM_MSB:TIM_LSB];
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[PWR_BIT]          = cfg_q.pwr;
    rdata_o[TIM_MSB:TIM_LSB]  = cfg_q.tim;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/flash_latch_set.sv
module flash_latch_set #(
  parameter int unsigned N_LAT = 4,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o,
  input  logic          fill_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i
);
  localparam int unsigned PW = (N_LAT > 1) ? $clog2(N_LAT) : 1;

  logic [N_LAT-1:0] valid_q;
  logic [N_LAT-1:0] hit_vec;
  logic [AW-1:0]    tag_q  [N_LAT];
  logic [DW-1:0]    data_q [N_LAT];
  logic [PW-1:0]    ptr_q;

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (fill_i && ptr_q == PW'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_addr_i;
        data_q[g]  <= fill_data_i;
      end
    end
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_addr_i);
  end

  // round-robin victim pointer, restarts at latch 0 on flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (flush_i) ptr_q <= '0;
    else if (fill_i)  ptr_q <= (ptr_q == PW'(N_LAT-1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < N_LAT; i++)
      if (hit_vec[i]) hit_data_o = hit_data_o | data_q[i];
  end
  assign hit_o = |hit_vec;

  // R6
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R7
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_wait_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          stall_i,
  input  cfg_t          cfg_i,
  input  logic          hit_i,
  input  logic [DW-1:0] hit_data_i,
  input  logic [DW-1:0] arr_data_i,
  output logic          ready_o,
  output logic          err_o,
  output logic [DW-1:0] data_o,
  output logic          arr_en_o,
  output logic [AW-1:0] arr_addr_o,
  output logic          fill_o,
  output seq_st_e       state_o
);
  seq_st_e       st_q, st_d;
  logic [3:0]    cnt_q;
  logic [3:0]    lim_m1;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          start;

  // codes above the safe value run at the safe length
  assign lim_m1 = (cfg_i.tim > TIM_SAFE) ? TIM_SAFE : cfg_i.tim;

  always_comb begin
    st_d    = st_q;
    ready_o = 1'b0;
    err_o   = 1'b0;
    data_o  = data_q;
    start   = 1'b0;
    fill_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i && !stall_i) begin
        if (!cfg_i.pwr) begin
          ready_o = 1'b1;
          err_o   = 1'b1;
        end else if (hit_i) begin
          ready_o = 1'b1;
          data_o  = hit_data_i;
        end else begin
          start = 1'b1;
          st_d  = ST_BUSY;
        end
      end
      ST_BUSY: if (cnt_q == '0) begin
        fill_o = 1'b1;
        st_d   = ST_DONE;
      end
      ST_DONE: begin
        ready_o = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cnt_q  <= lim_m1;
        addr_q <= req_addr_i;
      end else if (st_q == ST_BUSY && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (fill_o) data_q <= arr_data_i;
    end
  end

  assign arr_en_o   = (st_q == ST_BUSY);
  assign arr_addr_o = addr_q;
  assign state_o    = st_q;

  // R8
  err_no_array_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !arr_en_o);
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_en_o |-> (cnt_q <= TIM_SAFE));
  // R3
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_en_o |-> !ready_o);
  // R11
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_en_o && $past(arr_en_o)) |-> $stable(arr_addr_o));
endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl
  import flash_wait_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned N_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_addr_i,
  output logic             req_ready_o,
  output logic [DW-1:0]    rsp_data_o,
  output logic             rsp_err_o,
  output logic             arr_en_o,
  output logic [AW-1:0]    arr_addr_o,
  input  logic [DW-1:0]    arr_data_i
);
  cfg_t             cfg;
  seq_st_e          state;
  logic             pend_q;
  logic [CFG_W-1:0] pend_data_q;
  logic             apply_we;
  logic [CFG_W-1:0] apply_data;
  logic             hit;
  logic [DW-1:0]    hit_data;
  logic             fill;
  logic             stall;

  // writes during an access wait until its response cycle; newest wins
  assign apply_we   = (state == ST_IDLE && cfg_we_i) ||
                      (state == ST_DONE && (cfg_we_i || pend_q));
  assign apply_data = cfg_we_i ? cfg_wdata_i : pend_data_q;
  assign stall      = cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (apply_we) begin
      pend_q <= 1'b0;
    end else if (cfg_we_i && state == ST_BUSY) begin
      pend_q      <= 1'b1;
      pend_data_q <= cfg_wdata_i;
    end
  end

  flash_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (apply_we),
    .wdata_i (apply_data),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  flash_latch_set #(.N_LAT(N_LAT), .AW(AW), .DW(DW)) u_lat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (apply_we),
    .look_addr_i (req_addr_i),
    .hit_o       (hit),
    .hit_data_o  (hit_data),
    .fill_i      (fill),
    .fill_addr_i (arr_addr_o),
    .fill_data_i (arr_data_i)
  );

  flash_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .stall_i     (stall),
    .cfg_i       (cfg),
    .hit_i       (hit),
    .hit_data_i  (hit_data),
    .arr_data_i  (arr_data_i),
    .ready_o     (req_ready_o),
    .err_o       (rsp_err_o),
    .data_o      (rsp_data_o),
    .arr_en_o    (arr_en_o),
    .arr_addr_o  (arr_addr_o),
    .fill_o      (fill),
    .state_o     (state)
  );

  // R9
  defer_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BUSY && cfg_we_i) |=> $stable(cfg_rdata_o));
  // R10
  idle_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && cfg_we_i) |-> !req_ready_o);
endmodule

// File: tb/flash_wait_ctrl_test.sv
module flash_wait_ctrl_test;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;
  logic          arr_en;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]    m_tim;
  logic          m_pwr;
  logic [AW-1:0] m_tag [4];
  bit            m_val [4];
  int            m_ptr;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0001_9E37);
  endfunction

  assign arr_data = arr_en ? word_of(arr_addr) : '0;

  flash_wait_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
    .arr_en_o(arr_en), .arr_addr_o(arr_addr), .arr_data_i(arr_data)
  );

  function automatic int exp_len(logic [3:0] t);
    return (t > 4'd9) ? 10 : int'(t) + 1;
  endfunction

  function automatic int m_find(logic [AW-1:0] a);
    for (int i = 0; i < 4; i++) if (m_val[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_flush(logic [31:0] d);
    m_tim = d[15:12];
    m_pwr = d[31];
    for (int i = 0; i < 4; i++) m_val[i] = 0;
    m_ptr = 0;
  endtask

  task automatic cfg_wr(logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_flush(d);
  endtask

  // runs a request from the current falling edge until its handshake
  task automatic issue(logic [AW-1:0] a, string req);
    int lat = 0, en_cnt = 0;
    bit addr_bad = 0;
    int hit_idx;
    logic [DW-1:0] d;
    logic e;
    int exp_lat, exp_en;
    hit_idx = m_find(a);
    req_valid = 1'b1; req_addr = a;
    forever begin
      #1;
      if (arr_en) begin
        en_cnt++;
        if (arr_addr != a) addr_bad = 1;
      end
      if (req_ready) break;
      @(negedge clk);
      lat++;
      if (lat > 40) break;
    end
    d = rsp_data; e = rsp_err;
    @(negedge clk);
    req_valid = 1'b0;
    if (!m_pwr) begin
      chk(lat == 0, "R8", "error latency", lat, 0);
      chk(e == 1'b1, "R8", "error flag", e, 1);
      chk(en_cnt == 0, "R8", "array use while down", en_cnt, 0);
    end else begin
      exp_lat = (hit_idx >= 0) ? 0 : exp_len(m_tim) + 1;
      exp_en  = (hit_idx >= 0) ? 0 : exp_len(m_tim);
      chk(lat == exp_lat, req, "ready latency", lat, exp_lat);
      chk(en_cnt == exp_en, "R11", "array cycles", en_cnt, exp_en);
      chk(!addr_bad, "R11", "array address", arr_addr, a);
      chk(e == 1'b0, "R8", "error while powered", e, 0);
      chk(d == word_of(a), req, "read data", d, word_of(a));
      if (hit_idx < 0) begin
        m_tag[m_ptr] = a; m_val[m_ptr] = 1; m_ptr = (m_ptr + 1) % 4;
      end
    end
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    @(negedge clk);
    issue(a, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd4242));
    m_flush(32'h8000_9000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk(cfg_rdata == 32'h8000_9000, "R1", "reset config", cfg_rdata, 32'h8000_9000);
    chk(req_ready == 1'b0, "R1", "idle ready", req_ready, 0);

    // R2: reserved bits ignored and read zero
    cfg_wr(32'hFFFF_0FFF);
    #1 chk(cfg_rdata == 32'h8000_0000, "R2", "field layout", cfg_rdata, 32'h8000_0000);
    cfg_wr(32'h8000_5000);
    #1 chk(cfg_rdata == 32'h8000_5000, "R2", "code readback", cfg_rdata, 32'h8000_5000);

    // R3 miss then R5 hit
    cfg_wr(32'h8000_0000);
    rd(12'h005, "R3");
    rd(12'h005, "R5");
    cfg_wr(32'h8000_9000);
    rd(12'h010, "R3");
    // R4 clamp
    cfg_wr(32'h8000_F000);
    rd(12'h011, "R4");
    cfg_wr(32'h8000_C000);
    rd(12'h012, "R4");

    // R6 round robin over four latches
    cfg_wr(32'h8000_1000);
    for (int i = 0; i < 5; i++) rd(12'h100 + 12'(i), "R6");
    rd(12'h101, "R6");
    rd(12'h100, "R6");

    // R7 flush on rewrite of the same value
    rd(12'h104, "R7");
    cfg_wr(32'h8000_1000);
    rd(12'h104, "R7");

    // R8 power down
    cfg_wr(32'h0000_9000);
    rd(12'h104, "R8");
    rd(12'h200, "R8");
    cfg_wr(32'h8000_3000);

    // R9 write during an access is deferred
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h300;
    #1 chk(req_ready == 1'b0, "R9", "lookup cycle", req_ready, 0);
    @(negedge clk);
    lat = 1;
    cfg_we = 1'b1; cfg_wdata = 32'h8000_1000;
    @(negedge clk);
    lat = 2;
    cfg_we = 1'b0;
    #1 chk(cfg_rdata == 32'h8000_3000, "R9", "config held", cfg_rdata, 32'h8000_3000);
    while (!req_ready && lat < 40) begin
      @(negedge clk); lat++; #1;
    end
    chk(lat == 5, "R9", "old timing used", lat, 5);
    chk(rsp_data == word_of(12'h300), "R9", "data", rsp_data, word_of(12'h300));
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk(cfg_rdata == 32'h8000_1000, "R9", "config applied", cfg_rdata, 32'h8000_1000);
    m_flush(32'h8000_1000);
    rd(12'h300, "R9");

    // R10 write in idle stalls a same-cycle request
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h8000_2000;
    req_valid = 1'b1; req_addr = 12'h300;
    #1 chk(req_ready == 1'b0, "R10", "stalled ready", req_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_flush(32'h8000_2000);
    issue(12'h300, "R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 10 < 7) begin
        rd(12'($urandom % 8), "R5");
      end else begin
        logic [31:0] w;
        w = $urandom;
        w[31] = ($urandom % 6) != 0;
        cfg_wr(w);
        #1 chk(cfg_rdata == {w[31], 15'd0, w[15:12], 12'd0}, "R2", "random config",
               cfg_rdata, {w[31], 15'd0, w[15:12], 12'd0});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule